// File: doc/BRIEF.md
# Divider Configuration Register with Parallel and Serial Load

This block stores the settings a frequency-synthesis core needs: a 9-bit feedback divisor, a 2-bit output divisor and two test-mode bits. Two routes write the same register set. The parallel route follows a 6-bit and a 2-bit pin group while a latch control pin is low. It freezes those values when that pin rises. The serial route shifts a 14-bit frame in, one bit per serial clock edge, and commits the frame to the registers when a commit strobe rises. While the strobe stays high, every shifted bit is committed straight away.

Every pin is asynchronous to the system clock. Each pin passes through a two-stage synchronizer before it is used, and the serial clock and commit strobe then go through rising-edge detection. A master clear pin has priority over both routes. It zeroes the settings and the shift register, and it raises a flag that tells the output stage to hold its true output low and its inverted output high. The dividers, the loop and the output drivers are not part of this block.

Top module: `synth_divcfg`

## Requirements
- R1: While `par_latch_i` is low (and `clear_i` is low), `fb_div_o` equals `fb_div_pin_i` zero-extended to 9 bits, `out_div_o` equals `out_div_pin_i`, and `test_o` is 0. The outputs follow every change on those pins.
- R2: After `par_latch_i` rises, the outputs keep the last values taken from the pins, and later changes on `fb_div_pin_i` or `out_div_pin_i` have no effect on them.
- R3: Each rising edge of `ser_clk_i` shifts one bit (`ser_bit_i`) into the 14-bit shift register, but only while `par_latch_i` is high. While `ser_commit_i` is low, this shifting leaves the outputs unchanged. While `par_latch_i` is low, serial clock edges shift nothing.
- R4: The frame is sent in this order: `test_o[1]`, `test_o[0]`, one bit that is ignored, `out_div_o[1]`, `out_div_o[0]`, then `fb_div_o[8]` down to `fb_div_o[0]`. The first bit sent ends up in bit 13 of the shift register.
- R5: A rising edge of `ser_commit_i` while `par_latch_i` is high copies the whole shift register to all three outputs at once.
- R6: While `ser_commit_i` stays high, each serial clock edge shifts and then commits the result, so the outputs track the shifted data edge by edge.
- R7: After `ser_commit_i` falls, further serial shifting does not change the outputs until the strobe rises again.
- R8: Values that have been latched remain until `par_latch_i` goes high-to-low or a serial commit happens.
- R9: While `clear_i` is high it overrides every other input: all outputs read 0, the shift register is emptied, and `quiet_o` is 1. When `clear_i` is low, `quiet_o` is 0.
- R10: If a serial clock rising edge and a commit rising edge are detected in the same system cycle, the shift happens first and the commit copies the shifted contents.
- R11: A pin change shows on the outputs after the third rising `clk` edge following it, and not before. A serial clock pulse shifts exactly once, however long it stays high.
- R12: While `rst_n` is low at a `clk` edge, all outputs, including `quiet_o`, and the shift register are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| clear_i | input | 1 | Asynchronous master clear, active high |
| par_latch_i | input | 1 | Parallel route control: low follows the pins, high holds |
| fb_div_pin_i | input | 6 | Parallel feedback divisor pins |
| out_div_pin_i | input | 2 | Parallel output divisor pins |
| ser_clk_i | input | 1 | Serial shift clock, asynchronous |
| ser_commit_i | input | 1 | Serial commit strobe, asynchronous |
| ser_bit_i | input | 1 | Serial data bit |
| fb_div_o | output | 9 | Current feedback divisor |
| out_div_o | output | 2 | Current output divisor |
| test_o | output | 2 | Current test-mode bits |
| quiet_o | output | 1 | Reset-state flag for the output stage |

## Verification
Every pin passes through two synchronizer flops, and the decision then lands in the output register, so a result is due after the third rising clock edge that follows a pin change. Rising-edge responses take the same path, because the edge detector compares against the second synchronizer stage. The bench changes pins on falling clock edges and normally waits four rising edges before it samples outputs on a falling edge. In one directed case it samples after two edges and again after three, to pin down the exact latency. Serial clock and commit pulses are held for four system cycles on each level, so the bench model can apply one shift per pulse and its expected values stay correct.

// File: rtl/divcfg_pkg.sv
// Shared widths and the register-set type for the divider configuration block.
// Assumes the serial frame holds test bits, one gap bit, N bits and M bits.
package divcfg_pkg;
    parameter int M_PIN_W = 6;
    parameter int M_W     = 9;
    parameter int N_W     = 2;
    parameter int T_W     = 2;
    parameter int GAP_W   = 1;
    parameter int FRAME_W = T_W + GAP_W + N_W + M_W;

    typedef struct packed {
        logic [T_W-1:0] t;
        logic [N_W-1:0] n;
        logic [M_W-1:0] m;
    } cfg_t;
endpackage

// File: rtl/cdc_sync.sv
// Multi-flop synchronizer for a vector of asynchronous pins.
// Assumes each bit is independent, or that the bits are held stable around
// the moments they are used. RST_VAL is the idle level of each pin.
module cdc_sync #(
    parameter int             W       = 1,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    // First stage samples the raw pins.
    always_ff @(posedge clk) begin
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end

    genvar g;
    generate
        for (g = 1; g < STAGES; g++) begin : g_stage
            // Each later stage re-times the stage before it.
            always_ff @(posedge clk) begin
                if (!rst_n) stg[g] <= RST_VAL;
                else        stg[g] <= stg[g-1];
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/rise_det.sv
// Rising-edge detector for already-synchronized levels.
// Assumes the inputs come from the system-clock domain. Each rise is one cycle wide.
module rise_det #(
    parameter int           W       = 1,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);
    logic [W-1:0] prev_q;

    // Remember last cycle's level so each edge is seen exactly once.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= RST_VAL;
        else        prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

    p_single_pulse_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0))
        else $error("R11: edge pulse lasted more than one cycle");
endmodule

// File: rtl/frame_shifter.sv
// Serial configuration shift register. New bits enter at bit 0, so the first bit
// sent ends at the top. It exposes the decoded next value so that a commit in the
// same cycle as a shift uses the shifted contents.
module frame_shifter
    import divcfg_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic shift_en,
    input  logic din,
    output cfg_t nxt_cfg
);
    logic [FRAME_W-1:0] sr_q;
    logic [FRAME_W-1:0] sr_nxt;

    // Next contents: shift left by one when a serial edge is accepted.
    always_comb begin
        sr_nxt = sr_q;
        if (shift_en) sr_nxt = {sr_q[FRAME_W-2:0], din};
    end

    // Register update; master clear empties the frame.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) sr_q <= '0;
        else               sr_q <= sr_nxt;
    end

    // Decode the frame fields from the post-shift value.
    assign nxt_cfg.t = sr_nxt[FRAME_W-1 -: T_W];
    assign nxt_cfg.n = sr_nxt[M_W+N_W-1 -: N_W];
    assign nxt_cfg.m = sr_nxt[M_W-1:0];

    p_shift_in_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_en && !clr) |=> (sr_q[0] == $past(din)) &&
                               (sr_q[FRAME_W-1:1] == $past(sr_q[FRAME_W-2:0])))
        else $error("R3: shift did not move the frame by one bit");

    p_idle_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_en && !clr) |=> $stable(sr_q))
        else $error("R3: frame changed without a serial edge");
endmodule

// File: rtl/div_regs.sv
// Divider and test-bit register set with priority between the two routes:
// master clear, then parallel follow, then serial commit, else hold.
// Assumes all controls are already synchronized.
module div_regs
    import divcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mclr,
    input  logic               par_follow,
    input  logic [M_PIN_W-1:0] m_pin,
    input  logic [N_W-1:0]     n_pin,
    input  logic               commit,
    input  cfg_t               ser_cfg,
    output cfg_t               cfg_q,
    output logic               quiet_q
);
    localparam int PAD_W = M_W - M_PIN_W;

    // Reset-state flag follows the synchronized master clear.
    always_ff @(posedge clk) begin
        if (!rst_n) quiet_q <= 1'b0;
        else        quiet_q <= mclr;
    end

    // Register update in priority order.
    always_ff @(posedge clk) begin
        if (!rst_n || mclr) begin
            cfg_q <= '0;
        end else if (par_follow) begin
            cfg_q.t <= '0;
            cfg_q.n <= n_pin;
            cfg_q.m <= {{PAD_W{1'b0}}, m_pin};
        end else if (commit) begin
            cfg_q <= ser_cfg;
        end
    end

    p_mclr_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        mclr |=> (cfg_q == '0) && quiet_q)
        else $error("R9: master clear did not clear the register set");

    p_par_upper_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (!mclr && par_follow) |=> (cfg_q.t == '0) && (cfg_q.m[M_W-1:M_PIN_W] == '0))
        else $error("R1: parallel route left upper M or test bits set");

    p_latched_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!mclr && !par_follow && !commit) |=> $stable(cfg_q))
        else $error("R8: latched settings changed without a load");
endmodule

// File: rtl/synth_divcfg.sv
// Top of the divider configuration register. It synchronizes every pin,
// detects serial clock and commit edges, shifts the frame and drives the
// register set. Assumes serial data is stable while the serial clock rises.
module synth_divcfg
    import divcfg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               par_latch_i,
    input  logic [M_PIN_W-1:0] fb_div_pin_i,
    input  logic [N_W-1:0]     out_div_pin_i,
    input  logic               ser_clk_i,
    input  logic               ser_commit_i,
    input  logic               ser_bit_i,
    output logic [M_W-1:0]     fb_div_o,
    output logic [N_W-1:0]     out_div_o,
    output logic [T_W-1:0]     test_o,
    output logic               quiet_o
);
    localparam int SYNC_STAGES = 2;
    localparam int DATA_W      = M_PIN_W + N_W + 1;

    logic [3:0]         ctl_s;
    logic [DATA_W-1:0]  dat_s;
    logic [1:0]         edge_r;
    logic               mclr_s, latch_s, sclk_s, commit_s;
    logic [M_PIN_W-1:0] m_pin_s;
    logic [N_W-1:0]     n_pin_s;
    logic               bit_s;
    logic               serial_ok, shift_en, commit;
    cfg_t               ser_cfg, cfg_q;

    // Control pins; the latch pin idles high.
    cdc_sync #(.W(4), .STAGES(SYNC_STAGES), .RST_VAL(4'b0100)) i_ctl_sync (
        .clk(clk), .rst_n(rst_n),
        .d({clear_i, par_latch_i, ser_commit_i, ser_clk_i}), .q(ctl_s));

    // Data pins share the control latency so that they stay aligned.
    cdc_sync #(.W(DATA_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) i_dat_sync (
        .clk(clk), .rst_n(rst_n),
        .d({fb_div_pin_i, out_div_pin_i, ser_bit_i}), .q(dat_s));

    assign {mclr_s, latch_s, commit_s, sclk_s} = ctl_s;
    assign {m_pin_s, n_pin_s, bit_s}           = dat_s;

    rise_det #(.W(2), .RST_VAL(2'b00)) i_edges (
        .clk(clk), .rst_n(rst_n), .lvl({commit_s, sclk_s}), .rise(edge_r));

    // Serial route is live only with the latch high and no master clear.
    assign serial_ok = latch_s && !mclr_s;
    assign shift_en  = serial_ok && edge_r[0];
    assign commit    = serial_ok && (edge_r[1] || (commit_s && edge_r[0]));

    frame_shifter i_shift (
        .clk(clk), .rst_n(rst_n), .clr(mclr_s), .shift_en(shift_en),
        .din(bit_s), .nxt_cfg(ser_cfg));

    div_regs i_regs (
        .clk(clk), .rst_n(rst_n), .mclr(mclr_s), .par_follow(!latch_s),
        .m_pin(m_pin_s), .n_pin(n_pin_s), .commit(commit), .ser_cfg(ser_cfg),
        .cfg_q(cfg_q), .quiet_q(quiet_o));

    assign fb_div_o  = cfg_q.m;
    assign out_div_o = cfg_q.n;
    assign test_o    = cfg_q.t;

    p_quiet_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
        quiet_o |-> (fb_div_o == '0) && (out_div_o == '0) && (test_o == '0))
        else $error("R9: outputs nonzero while reset-state flag is up");
endmodule

// File: tb/test_synth_divcfg.sv
`timescale 1ns/1ps
// Self-checking bench: directed corner cases followed by seeded random operations,
// checked against a model of the requirements.
module test_synth_divcfg;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clear_i = 1'b0;
    logic       par_latch_i = 1'b1;
    logic [5:0] fb_div_pin_i = '0;
    logic [1:0] out_div_pin_i = '0;
    logic       ser_clk_i = 1'b0;
    logic       ser_commit_i = 1'b0;
    logic       ser_bit_i = 1'b0;
    logic [8:0] fb_div_o;
    logic [1:0] out_div_o;
    logic [1:0] test_o;
    logic       quiet_o;

    int checks = 0;
    int fails  = 0;
    logic [13:0] exp_sr = '0;
    logic [8:0]  exp_m = '0;
    logic [1:0]  exp_n = '0;
    logic [1:0]  exp_t = '0;
    logic        exp_q = 1'b0;

    always #10 clk = ~clk;

    synth_divcfg i_synth_divcfg (
        .clk(clk), .rst_n(rst_n), .clear_i(clear_i), .par_latch_i(par_latch_i),
        .fb_div_pin_i(fb_div_pin_i), .out_div_pin_i(out_div_pin_i),
        .ser_clk_i(ser_clk_i), .ser_commit_i(ser_commit_i), .ser_bit_i(ser_bit_i),
        .fb_div_o(fb_div_o), .out_div_o(out_div_o), .test_o(test_o), .quiet_o(quiet_o));

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk(input string req, input string what, input logic [31:0] got, input logic [31:0] expv);
        checks++;
        if (got !== expv) begin
            fails++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, got, expv);
        end
    endtask

    task automatic chk_all(input string req);
        chk(req, "fb_div", 32'(fb_div_o), 32'(exp_m));
        chk(req, "out_div", 32'(out_div_o), 32'(exp_n));
        chk(req, "test", 32'(test_o), 32'(exp_t));
        chk(req, "quiet", 32'(quiet_o), 32'(exp_q));
    endtask

    // Model: the parallel route follows the pins while the latch is low.
    task automatic mdl_par();
        if (!clear_i && !par_latch_i) begin
            exp_m = {3'b000, fb_div_pin_i};
            exp_n = out_div_pin_i;
            exp_t = 2'b00;
        end
    endtask

    task automatic mdl_copy();
        exp_t = exp_sr[13:12];
        exp_n = exp_sr[10:9];
        exp_m = exp_sr[8:0];
    endtask

    task automatic set_pins(input logic [5:0] m, input logic [1:0] n);
        fb_div_pin_i = m; out_div_pin_i = n;
        mdl_par();
        tick(4);
    endtask

    task automatic set_latch(input logic v);
        par_latch_i = v;
        mdl_par();
        tick(4);
    endtask

    task automatic sclk_pulse(input logic d);
        ser_bit_i = d;
        ser_clk_i = 1'b1;
        if (par_latch_i && !clear_i) begin
            exp_sr = {exp_sr[12:0], d};
            if (ser_commit_i) mdl_copy();
        end
        tick(4);
        ser_clk_i = 1'b0;
        tick(4);
    endtask

    task automatic set_commit(input logic v);
        if (v && !ser_commit_i && par_latch_i && !clear_i) mdl_copy();
        ser_commit_i = v;
        tick(4);
    endtask

    task automatic both_rise(input logic d);
        ser_bit_i = d;
        ser_clk_i = 1'b1;
        ser_commit_i = 1'b1;
        if (par_latch_i && !clear_i) begin
            exp_sr = {exp_sr[12:0], d};
            mdl_copy();
        end
        tick(4);
        ser_clk_i = 1'b0;
        tick(4);
    endtask

    task automatic set_clear(input logic v);
        clear_i = v;
        if (v) begin
            exp_m = '0; exp_n = '0; exp_t = '0; exp_sr = '0; exp_q = 1'b1;
        end else begin
            exp_q = 1'b0;
            mdl_par();
        end
        tick(4);
    endtask

    task automatic send_frame(input logic [13:0] f);
        for (int i = 13; i >= 0; i--) sclk_pulse(f[i]);
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL R11 watchdog expired: got 0 expected 1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        tick(5);
        chk_all("R12");
        rst_n = 1'b1;
        tick(4);
        chk_all("R12");

        // R1: transparent parallel route.
        set_latch(1'b0);
        set_pins(6'd45, 2'd2);
        chk_all("R1");
        set_pins(6'd17, 2'd1);
        chk_all("R1");

        // R11: exact latency of a pin change.
        fb_div_pin_i = 6'd63;
        tick(2);
        chk("R11", "fb_div early", 32'(fb_div_o), 32'd17);
        tick(1);
        chk("R11", "fb_div due", 32'(fb_div_o), 32'd63);
        mdl_par();
        tick(2);

        // R3: serial edges shift nothing while the latch is low.
        sclk_pulse(1'b1);
        sclk_pulse(1'b1);

        // R2: capture, then pins are ignored.
        set_latch(1'b1);
        set_pins(6'd5, 2'd3);
        chk_all("R2");

        // R3, R4, R5: full frame, no change until commit, then field mapping.
        send_frame(14'b10_0_01_101010101);
        chk_all("R3");
        set_commit(1'b1);
        chk_all("R5");
        chk("R4", "test", 32'(test_o), 32'd2);
        chk("R4", "out_div", 32'(out_div_o), 32'd1);
        chk("R4", "fb_div", 32'(fb_div_o), 32'h155);

        // R6: data flows through while the strobe stays high.
        sclk_pulse(1'b1);
        chk_all("R6");
        sclk_pulse(1'b0);
        chk_all("R6");

        // R7: strobe falls, later shifting is held back.
        set_commit(1'b0);
        sclk_pulse(1'b1);
        sclk_pulse(1'b1);
        chk_all("R7");

        // R11: a long serial clock pulse shifts once only.
        ser_bit_i = 1'b0;
        ser_clk_i = 1'b1;
        exp_sr = {exp_sr[12:0], 1'b0};
        tick(12);
        ser_clk_i = 1'b0;
        tick(4);
        set_commit(1'b1);
        chk_all("R11");
        set_commit(1'b0);

        // R10: simultaneous edges, shift before the commit.
        both_rise(1'b1);
        chk_all("R10");
        set_commit(1'b0);

        // R8: latched values persist until the latch pin falls.
        set_pins(6'd9, 2'd0);
        chk_all("R8");
        set_latch(1'b0);
        chk_all("R8");
        set_latch(1'b1);

        // R9: master clear overrides, and the frame is emptied.
        send_frame(14'h3fff);
        set_clear(1'b1);
        chk_all("R9");
        sclk_pulse(1'b1);
        set_commit(1'b1);
        chk_all("R9");
        set_commit(1'b0);
        set_clear(1'b0);
        chk_all("R9");
        set_commit(1'b1);
        chk_all("R9");
        set_commit(1'b0);

        // Random operations mixed across both routes.
        for (int k = 0; k < 80; k++) begin
            int op;
            op = int'($urandom % 7);
            case (op)
                0: begin set_pins(6'($urandom), 2'($urandom)); chk_all(par_latch_i ? "R2" : "R1"); end
                1: begin set_latch(~par_latch_i); chk_all("R8"); end
                2, 3: begin sclk_pulse(1'($urandom)); chk_all(ser_commit_i ? "R6" : "R7"); end
                4: begin set_commit(~ser_commit_i); chk_all("R5"); end
                5: begin
                    if (!ser_commit_i && !ser_clk_i) begin both_rise(1'($urandom)); chk_all("R10"); end
                   end
                default: begin
                    if (($urandom % 4) == 0) begin set_clear(1'b1); chk_all("R9"); set_clear(1'b0); chk_all("R9"); end
                end
            endcase
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule